// File: doc/BRIEF.md
# Branch Resolution Unit

This block settles one branch instruction of a 32-bit fixed-width RISC instruction set. Each cycle it takes an instruction word together with the current program counter, the count and link registers, the 32-bit condition register and an address-mode flag. One cycle later it presents the next program counter, the new count and link register values and a taken flag.

It handles four branch shapes. The first is an unconditional jump with a 24-bit word offset. The second is a conditional jump with a 14-bit word offset. The last two are conditional jumps whose target is the link register or the count register. For the conditional shapes, a 5-bit option field decides two things: whether the count register is decremented and tested, and whether one condition-register bit is compared with an expected value. Any other opcode passes straight through: the program counter advances by four and no register changes.

The decision and target logic is combinational. One register stage sits at the output.

Top module: `brc_unit`

## Requirements
- R1: While rst_ni is low, valid_o, taken_o, next_pc_o, ctr_o and lr_o are all zero.
- R2: Results for inputs presented with valid_i high appear on the outputs at the next rising clock edge, and valid_o is high there. A cycle with valid_i low gives valid_o low one edge later.
- R3: For a conditional shape (primary opcode, bits 31..26, equal to 16, or equal to 19 with bits 10..1 equal to 16 or 528) whose option bit 2 (instruction bit 23) is clear, ctr_o is ctr_i minus one. This holds whether or not the branch is taken. In every other case ctr_o equals ctr_i.
- R4: When option bit 2 is clear, the branch is not taken unless (ctr_i - 1 == 0) equals option bit 1 (instruction bit 22).
- R5: When option bit 4 (instruction bit 25) is clear, the branch is not taken unless condition-register bit (31 - n) equals option bit 3 (instruction bit 24). Here n is instruction bits 20..16. A conditional shape that passes both enabled tests is taken.
- R6: A taken opcode-16 branch goes to the sign extension of {bits 15..2, 2'b00}. The current PC is added to it unless instruction bit 1 is set.
- R7: Opcode 18 is always taken and leaves the count unchanged. It goes to the sign extension of {bits 25..2, 2'b00}, with the PC added unless bit 1 is set.
- R8: Opcode 19 with bits 10..1 equal to 528 goes to ctr_i. With bits 10..1 equal to 16 it goes to lr_i. In both cases the target is read from the input values, before any count or link update.
- R9: For any of the four branch shapes with instruction bit 0 set, lr_o is PC+4 (after mode truncation), whether or not the branch is taken. Otherwise lr_o equals lr_i.
- R10: When taken_o is low, next_pc_o is PC+4.
- R11: With mode64_i low, next_pc_o and the link value written to lr_o keep only their low 32 bits, and the upper bits are zero.
- R12: Any other opcode, including opcode 19 with another bits 10..1 value, gives taken_o low, next_pc_o = PC+4, and leaves ctr_o and lr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs hold a branch to resolve |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| ctr_i | input | XLEN | Count register |
| lr_i | input | XLEN | Link register |
| cr_i | input | 32 | Condition register, bit 31 is index 0 |
| mode64_i | input | 1 | 1: full-width addressing, 0: 32-bit addressing |
| valid_o | output | 1 | Registered results are valid |
| next_pc_o | output | XLEN | Address of the next instruction |
| ctr_o | output | XLEN | Updated count register |
| lr_o | output | XLEN | Updated link register |
| taken_o | output | 1 | Branch was taken |

## Verification
The bench builds the unit at its default XLEN of 64. This exposes the 32-bit truncation, because high program-counter bits can be set and must be cleared in 32-bit mode. It sweeps all 32 option-field values for every branch shape, in both address modes, with both values of the selected condition bit. Count inputs of 0, 1, 2 and a wide random value cover the points where the decremented count crosses zero.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned CR_W    = 32;

  localparam logic [5:0] OPC_BCOND   = 6'd16;
  localparam logic [5:0] OPC_BUNCOND = 6'd18;
  localparam logic [5:0] OPC_BREG    = 6'd19;
  localparam logic [9:0] XOP_TO_LR   = 10'd16;
  localparam logic [9:0] XOP_TO_CTR  = 10'd528;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_DISP,
    FORM_UNCOND,
    FORM_REG_LR,
    FORM_REG_CTR
  } brc_form_e;

  typedef struct packed {
    brc_form_e  form;
    logic [4:0] opt;
    logic [4:0] idx;
    logic       abs_addr;
    logic       link_en;
  } brc_dec_t;

  function automatic logic is_cond(brc_form_e f);
    return (f == FORM_DISP) || (f == FORM_REG_LR) || (f == FORM_REG_CTR);
  endfunction
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output brc_dec_t           dec_o
);
  logic [5:0] opc;
  logic [9:0] xop;
  brc_form_e  form;
  logic       unused_bits;

  assign opc         = instr_i[31:26];
  assign xop         = instr_i[10:1];
  assign unused_bits = ^instr_i[15:11];

  always_comb begin
    form = FORM_NONE;
    unique case (opc)
      OPC_BCOND:   form = FORM_DISP;
      OPC_BUNCOND: form = FORM_UNCOND;
      OPC_BREG: begin
        if (xop == XOP_TO_LR)       form = FORM_REG_LR;
        else if (xop == XOP_TO_CTR) form = FORM_REG_CTR;
      end
      default: form = FORM_NONE;
    endcase
  end

  always_comb begin
    dec_o.form     = form;
    dec_o.opt      = instr_i[25:21];
    dec_o.idx      = instr_i[20:16];
    dec_o.abs_addr = instr_i[1];
    dec_o.link_en  = instr_i[0] && (form != FORM_NONE);
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  brc_form_e       form_i,
  input  logic [4:0]      opt_i,
  input  logic [4:0]      idx_i,
  input  logic [CR_W-1:0] cr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic            taken_o,
  output logic [XLEN-1:0] ctr_o
);
  logic            cond;
  logic            use_ctr;
  logic [XLEN-1:0] ctr_dec;
  logic            ctr_zero;
  logic            ctr_ok;
  logic            cr_bit;
  logic            cr_ok;

  assign cond     = is_cond(form_i);
  assign use_ctr  = cond && !opt_i[2];
  assign ctr_dec  = ctr_i - XLEN'(1);
  assign ctr_zero = (ctr_dec == '0);
  // condition bits are numbered from the MSB
  assign cr_bit   = cr_i[CR_W-1-int'(idx_i)];

  // the decrement is committed even when the branch falls through
  assign ctr_o    = use_ctr ? ctr_dec : ctr_i;
  assign ctr_ok   = opt_i[2] || (ctr_zero == opt_i[1]);
  assign cr_ok    = opt_i[4] || (cr_bit == opt_i[3]);
  assign taken_o  = (form_i == FORM_UNCOND) || (cond && ctr_ok && cr_ok);
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  brc_form_e          form_i,
  input  logic               abs_addr_i,
  input  logic               taken_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    ctr_i,
  input  logic [XLEN-1:0]    lr_i,
  input  logic               mode64_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic [XLEN-1:0]    link_o
);
  localparam int unsigned DISP_S_W = 16;
  localparam int unsigned DISP_L_W = 26;

  logic [XLEN-1:0] disp_s;
  logic [XLEN-1:0] disp_l;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] seq;
  logic [XLEN-1:0] pc_full;
  logic            unused_bits;

  assign unused_bits = ^{instr_i[31:26], instr_i[0]};
  assign disp_s = {{(XLEN-DISP_S_W){instr_i[15]}}, instr_i[15:2], 2'b00};
  assign disp_l = {{(XLEN-DISP_L_W){instr_i[25]}}, instr_i[25:2], 2'b00};
  assign base   = abs_addr_i ? '0 : pc_i;
  assign seq    = pc_i + XLEN'(4);

  always_comb begin
    unique case (form_i)
      FORM_DISP:    target = base + disp_s;
      FORM_UNCOND:  target = base + disp_l;
      FORM_REG_LR:  target = lr_i;   // value before link update
      FORM_REG_CTR: target = ctr_i;  // value before decrement
      default:      target = seq;
    endcase
  end

  assign pc_full = taken_i ? target : seq;

  generate
    if (XLEN > 32) begin : g_trunc
      assign next_pc_o = mode64_i ? pc_full : {{(XLEN-32){1'b0}}, pc_full[31:0]};
      assign link_o    = mode64_i ? seq     : {{(XLEN-32){1'b0}}, seq[31:0]};
    end else begin : g_flat
      logic unused_mode;
      assign unused_mode = mode64_i;
      assign next_pc_o   = pc_full;
      assign link_o      = seq;
    end
  endgenerate
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    ctr_i,
  input  logic [XLEN-1:0]    lr_i,
  input  logic [CR_W-1:0]    cr_i,
  input  logic               mode64_i,
  output logic               valid_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic [XLEN-1:0]    ctr_o,
  output logic [XLEN-1:0]    lr_o,
  output logic               taken_o
);
  brc_dec_t        dec;
  logic            taken_d;
  logic [XLEN-1:0] ctr_d;
  logic [XLEN-1:0] npc_d;
  logic [XLEN-1:0] link_val;
  logic [XLEN-1:0] lr_d;

  brc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  brc_cond_eval #(.XLEN(XLEN)) u_cond (
    .form_i  (dec.form),
    .opt_i   (dec.opt),
    .idx_i   (dec.idx),
    .cr_i    (cr_i),
    .ctr_i   (ctr_i),
    .taken_o (taken_d),
    .ctr_o   (ctr_d)
  );

  brc_target_gen #(.XLEN(XLEN)) u_tgt (
    .form_i     (dec.form),
    .abs_addr_i (dec.abs_addr),
    .taken_i    (taken_d),
    .instr_i    (instr_i),
    .pc_i       (pc_i),
    .ctr_i      (ctr_i),
    .lr_i       (lr_i),
    .mode64_i   (mode64_i),
    .next_pc_o  (npc_d),
    .link_o     (link_val)
  );

  assign lr_d = dec.link_en ? link_val : lr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      next_pc_o <= '0;
      ctr_o     <= '0;
      lr_o      <= '0;
      taken_o   <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      next_pc_o <= npc_d;
      ctr_o     <= ctr_d;
      lr_o      <= lr_d;
      taken_o   <= taken_d;
    end
  end

  logic [XLEN-1:0] seq_chk;
  assign seq_chk = pc_i + XLEN'(4);

  // R3
  ctr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[23] || !(instr_i[31:26] == OPC_BCOND || instr_i[31:26] == OPC_BREG))
    |=> ctr_o == $past(ctr_i));

  // R7
  uncond_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[31:26] == OPC_BUNCOND |=> taken_o);

  // R9
  lr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !instr_i[0] |=> lr_o == $past(lr_i));

  generate
    if (XLEN > 32) begin : g_chk
      // R10
      fallthrough_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> taken_o || next_pc_o ==
          ($past(mode64_i) ? $past(seq_chk) : {{(XLEN-32){1'b0}}, $past(seq_chk[31:0])}));

      // R11
      mode32_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && !mode64_i |=> next_pc_o[XLEN-1:32] == '0);
    end
  endgenerate
endmodule

// File: tb/brc_unit_tb.sv
module brc_unit_tb;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] pc_i = '0, ctr_i = '0, lr_i = '0;
  logic [31:0]     cr_i = '0;
  logic            mode64_i = 1'b1;
  logic            valid_o, taken_o;
  logic [XLEN-1:0] next_pc_o, ctr_o, lr_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brc_unit #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .ctr_i(ctr_i), .lr_i(lr_i), .cr_i(cr_i), .mode64_i(mode64_i),
    .valid_o(valid_o), .next_pc_o(next_pc_o), .ctr_o(ctr_o), .lr_o(lr_o),
    .taken_o(taken_o)
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] trn(logic m64, logic [63:0] v);
    return m64 ? v : {32'b0, v[31:0]};
  endfunction

  // form: 0 other, 1 short displacement, 2 long displacement, 3 to link, 4 to count
  task automatic expect_model(input int form, input logic [31:0] ins, input logic [63:0] pc,
                              input logic [63:0] ctr, input logic [63:0] lr,
                              input logic [31:0] cr, input logic m64,
                              output logic [63:0] npc, output logic [63:0] octr,
                              output logic [63:0] olr, output logic tk);
    logic [4:0]  bo = ins[25:21];
    logic [4:0]  bi = ins[20:16];
    logic [63:0] dec = ctr - 64'd1;
    logic        ok_c, ok_r;
    logic [63:0] tgt;
    octr = ctr;
    olr  = lr;
    tk   = 1'b0;
    tgt  = pc + 64'd4;
    if (form == 2) begin
      tk  = 1'b1;
      tgt = 64'($signed({ins[25:2], 2'b00})) + (ins[1] ? 64'd0 : pc);
    end else if (form != 0) begin
      if (!bo[2]) octr = dec;
      ok_c = bo[2] || ((dec == 64'd0) == bo[1]);
      ok_r = bo[4] || (cr[31 - int'(bi)] == bo[3]);
      tk   = ok_c && ok_r;
      if (form == 1) tgt = 64'($signed({ins[15:2], 2'b00})) + (ins[1] ? 64'd0 : pc);
      else if (form == 3) tgt = lr;
      else tgt = ctr;
    end
    if (form != 0 && ins[0]) olr = trn(m64, pc + 64'd4);
    npc = tk ? trn(m64, tgt) : trn(m64, pc + 64'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", {63'b0, valid_o}, 64'd0);
    chk("R1 taken", {63'b0, taken_o}, 64'd0);
    chk("R1 npc", next_pc_o, 64'd0);
    chk("R1 ctr", ctr_o, 64'd0);
    chk("R1 lr", lr_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int form = 0; form < 5; form++)
      for (int bo = 0; bo < 32; bo++)
        for (int cs = 0; cs < 4; cs++)
          for (int cb = 0; cb < 2; cb++)
            for (int m = 0; m < 2; m++) begin
              logic [31:0] ins, cr;
              logic [4:0]  bi;
              logic [63:0] pc, ctr, lr, e_npc, e_ctr, e_lr;
              logic        e_tk, lk, aa;
              string       ptag;
              bi = 5'($urandom % 32);
              lk = 1'($urandom);
              aa = 1'($urandom);
              cr = $urandom;
              cr[31 - int'(bi)] = 1'(cb);
              pc = {$urandom, $urandom} & ~64'd3;
              lr = {$urandom, $urandom};
              case (cs)
                0: ctr = 64'd0;
                1: ctr = 64'd1;
                2: ctr = 64'd2;
                default: ctr = {$urandom, $urandom};
              endcase
              case (form)
                1: ins = {6'd16, 5'(bo), bi, 14'($urandom), aa, lk};
                2: ins = {6'd18, 24'($urandom), aa, lk};
                3: ins = {6'd19, 5'(bo), bi, 5'd0, 10'd16, lk};
                4: ins = {6'd19, 5'(bo), bi, 5'd0, 10'd528, lk};
                default: ins = (bo % 2 == 0) ? {6'd31, 26'($urandom)}
                                             : {6'd19, 5'(bo), bi, 5'd0, 10'd150, lk};
              endcase
              expect_model(form, ins, pc, ctr, lr, cr, 1'(m), e_npc, e_ctr, e_lr, e_tk);
              instr_i = ins; pc_i = pc; ctr_i = ctr; lr_i = lr; cr_i = cr;
              mode64_i = 1'(m); valid_i = 1'b1;
              @(negedge clk);
              case (form)
                1: ptag = "R6";
                2: ptag = "R7";
                3, 4: ptag = "R8";
                default: ptag = "R12";
              endcase
              if (!e_tk) ptag = {ptag, " R10"};
              if (m == 0) ptag = {ptag, " R11"};
              chk("R2 valid", {63'b0, valid_o}, 64'd1);
              chk(ptag, next_pc_o, e_npc);
              chk((form == 2) ? "R7 taken" : "R4 R5 taken", {63'b0, taken_o}, {63'b0, e_tk});
              chk("R3 ctr", ctr_o, e_ctr);
              chk("R9 lr", lr_o, e_lr);
            end

    valid_i = 1'b0;
    @(negedge clk);
    chk("R2 idle", {63'b0, valid_o}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule